// File: doc/BRIEF.md
# Core Idle Depth Arbiter with Residency-Based Demotion

This block keeps the idle power state of a small group of processor cores. A running core raises a sleep request tagged with a target depth. The controller grants that depth or a shallower one and holds it as the core's current state until an interrupt to that core brings it back to running. The result goes out on a registered grant port, one cycle after the request.

Each core has its own residency counter and a small history counter. A deep request (power-off depth or deeper) made while demotion is enabled is granted as a plain halt until the core has built up a record of long sleeps. A run of short sleeps between interrupts pulls the record down and brings the demotion back. A combined module state reports whether any core runs, whether all cores sit in a deep state, or whether all are idle with at least one of them shallow.

Top module: `idle_ctl`

## Requirements
- R1: After reset every core reads running (code 0), no grant is valid, the module state is 0, and every core's history is zero, so a deep request with demotion enabled is granted as halt.
- R2: Depth codes are 0 running, 1 halt, 2 halt at lowest operating point, 3 power-off, 4 power-off allowing module sleep, 5 cache-shrink, 6 deepest. When demotion is off, a request from a running core with no interrupt is granted at the requested depth one cycle later (grant_valid high for one cycle), and the core state becomes that depth.
- R3: An interrupt to a sleeping core makes its state 0 on the next cycle.
- R4: A request and an interrupt to the same core in the same cycle produce a valid grant of depth 0, and the core stays running.
- R5: A request to a core that is not running is ignored: no grant, and the state does not change.
- R6: With demotion enabled, a request of depth 3 or more is granted as depth 1 while the core's history is below 2. Depths 1 and 2 are never demoted.
- R7: The residency count is the number of cycles a core has spent asleep before its waking edge. A sleep is long when that count is at least res_thresh. The 2-bit history counts up, saturating at 3, on each long sleep and down, saturating at 0, on each short sleep. Deep requests are granted as asked once the history is 2 or more.
- R8: Short sleeps that follow a high history lower it until deep requests are demoted again.
- R9: Module state is 0 when any core runs, 2 when every core is at depth 3 or deeper, and 1 otherwise.
- R10: The residency count saturates at its maximum value and does not wrap. A sleep longer than that maximum counts as long even when res_thresh equals the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| demote_en | input | 1 | Enables residency-based demotion |
| res_thresh | input | RES_W | Residency count at which a sleep counts as long |
| req_valid | input | NCORES | Per-core sleep request strobe |
| req_depth | input | 3*NCORES | Per-core requested depth code |
| irq | input | NCORES | Per-core interrupt; wakes the core |
| grant_valid | output | NCORES | Per-core grant strobe, one cycle after a request |
| grant_depth | output | 3*NCORES | Per-core granted depth |
| core_state | output | 3*NCORES | Per-core current depth |
| mod_state | output | 2 | Combined module state |

## Verification
The hardest state to reach from the ports is a core whose history sits at a chosen value just as a deep request arrives, because the history is never visible directly. The bench keeps its own history model for each core and drives sweeps of requests, each followed by a sleep a set number of cycles long on either side of the threshold. The granted depth then shows whether the hidden counter moved as the model expects. Saturation of the residency count needs a sleep longer than its range with the threshold set at the maximum. Three such sleeps in a row must raise the history far enough for a deepest-depth request to be granted as asked.

// File: rtl/idle_pkg.sv
package idle_pkg;

    localparam int DEPTH_W   = 3;
    localparam int HIST_W    = 2;
    localparam int HIST_GATE = 2;

    typedef enum logic [DEPTH_W-1:0] {
        D_RUN      = 3'd0,
        D_HALT     = 3'd1,
        D_HALT_LOW = 3'd2,
        D_OFF      = 3'd3,
        D_OFF_MOD  = 3'd4,
        D_SHRINK   = 3'd5,
        D_DEEPEST  = 3'd6
    } depth_e;

    typedef enum logic [1:0] {
        M_ACTIVE = 2'd0,
        M_IDLE   = 2'd1,
        M_DEEP   = 2'd2
    } mod_e;

    function automatic logic is_deep(input logic [DEPTH_W-1:0] d);
        return d >= DEPTH_W'(D_OFF);
    endfunction

    function automatic logic [HIST_W-1:0] hist_step(input logic [HIST_W-1:0] h,
                                                    input logic up);
        if (up)
            return (h == '1) ? h : h + 1'b1;
        else
            return (h == '0) ? h : h - 1'b1;
    endfunction

endpackage

// File: rtl/idle_resid.sv
module idle_resid
    import idle_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sleeping,
    input  logic              wake,
    input  logic [RES_W-1:0]  thresh,
    output logic [HIST_W-1:0] hist
);
    localparam logic [RES_W-1:0] RES_MAX = '1;

    logic [RES_W-1:0] res;

    always_ff @(posedge clk) begin
        if (rst) begin
            res  <= '0;
            hist <= '0;
        end else begin
            if (start)
                res <= '0;
            else if (sleeping && !wake && res != RES_MAX)
                res <= res + 1'b1;
            if (wake)
                hist <= hist_step(hist, res >= thresh);
        end
    end

    // R10: once at the top, the count holds there while the sleep goes on
    a_r10_res_saturates: assert property (@(posedge clk) disable iff (rst)
        (sleeping && !start && !wake && res == RES_MAX) |=> res == RES_MAX);

    // R7: a long sleep raises a non-saturated history by exactly one
    a_r7_long_raises: assert property (@(posedge clk) disable iff (rst)
        (wake && res >= thresh && hist != '1) |=> hist == $past(hist) + 1'b1);

endmodule

// File: rtl/idle_core.sv
module idle_core
    import idle_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               demote_en,
    input  logic [RES_W-1:0]   thresh,
    input  logic               req_valid,
    input  logic [DEPTH_W-1:0] req_depth,
    input  logic               irq,
    output logic               grant_valid,
    output logic [DEPTH_W-1:0] grant_depth,
    output logic [DEPTH_W-1:0] state
);
    depth_e            cur;
    depth_e            want;
    depth_e            pick;
    logic              running;
    logic              accept;
    logic              demote;
    logic              start;
    logic              wake;
    logic [HIST_W-1:0] hist;

    always_comb begin
        running = (cur == D_RUN);
        accept  = req_valid && running;
        want    = depth_e'(req_depth);
        demote  = demote_en && is_deep(req_depth) && (hist < HIST_W'(HIST_GATE));
        if (irq)
            pick = D_RUN;
        else if (demote)
            pick = D_HALT;
        else
            pick = want;
        start = accept && (pick != D_RUN);
        wake  = irq && !running;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur         <= D_RUN;
            grant_valid <= 1'b0;
            grant_depth <= '0;
        end else begin
            grant_valid <= accept;
            if (accept) begin
                grant_depth <= pick;
                cur         <= pick;
            end else if (irq) begin
                cur <= D_RUN;
            end
        end
    end

    assign state = cur;

    idle_resid #(.RES_W(RES_W)) u_resid (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sleeping (!running),
        .wake     (wake),
        .thresh   (thresh),
        .hist     (hist)
    );

    a_r3_irq_wakes: assert property (@(posedge clk) disable iff (rst)
        irq |=> state == DEPTH_W'(D_RUN));

    a_r4_collision_runs: assert property (@(posedge clk) disable iff (rst)
        (req_valid && running && irq) |=> (grant_valid && grant_depth == DEPTH_W'(D_RUN)));

    a_r5_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !running && !irq) |=> (!grant_valid && $stable(state)));

    a_r6_deep_needs_history: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && is_deep(grant_depth)) |-> $past(!demote_en || hist >= HIST_W'(HIST_GATE)));

endmodule

// File: rtl/idle_merge.sv
module idle_merge
    import idle_pkg::*;
#(
    parameter int NCORES = 4
) (
    input  logic [NCORES*DEPTH_W-1:0] states,
    output mod_e                      mod
);
    logic [NCORES-1:0] run_v;
    logic [NCORES-1:0] deep_v;

    for (genvar i = 0; i < NCORES; i++) begin : g_flag
        assign run_v[i]  = (states[i*DEPTH_W +: DEPTH_W] == DEPTH_W'(D_RUN));
        assign deep_v[i] = is_deep(states[i*DEPTH_W +: DEPTH_W]);
    end

    always_comb begin
        if (|run_v)
            mod = M_ACTIVE;
        else if (&deep_v)
            mod = M_DEEP;
        else
            mod = M_IDLE;
    end

endmodule

// File: rtl/idle_ctl.sv
module idle_ctl
    import idle_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int RES_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        demote_en,
    input  logic [RES_W-1:0]            res_thresh,
    input  logic [NCORES-1:0]           req_valid,
    input  logic [NCORES*DEPTH_W-1:0]   req_depth,
    input  logic [NCORES-1:0]           irq,
    output logic [NCORES-1:0]           grant_valid,
    output logic [NCORES*DEPTH_W-1:0]   grant_depth,
    output logic [NCORES*DEPTH_W-1:0]   core_state,
    output logic [1:0]                  mod_state
);
    mod_e merged;

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        idle_core #(.RES_W(RES_W)) u_core (
            .clk         (clk),
            .rst         (rst),
            .demote_en   (demote_en),
            .thresh      (res_thresh),
            .req_valid   (req_valid[c]),
            .req_depth   (req_depth[c*DEPTH_W +: DEPTH_W]),
            .irq         (irq[c]),
            .grant_valid (grant_valid[c]),
            .grant_depth (grant_depth[c*DEPTH_W +: DEPTH_W]),
            .state       (core_state[c*DEPTH_W +: DEPTH_W])
        );
    end

    idle_merge #(.NCORES(NCORES)) u_merge (
        .states (core_state),
        .mod    (merged)
    );

    assign mod_state = merged;

    // R9: interrupting every core leaves the module active on the next cycle
    a_r9_all_irq_active: assert property (@(posedge clk) disable iff (rst)
        (&irq) |=> mod_state == 2'(M_ACTIVE));

endmodule

// File: tb/idle_ctl_tb.sv
module idle_ctl_tb;
    localparam int N  = 4;
    localparam int RW = 8;
    localparam int RMAX = (1 << RW) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            demote_en = 1'b0;
    logic [RW-1:0]   res_thresh = 8'd4;
    logic [N-1:0]    req_valid = '0;
    logic [N*3-1:0]  req_depth = '0;
    logic [N-1:0]    irq = '0;
    logic [N-1:0]    grant_valid;
    logic [N*3-1:0]  grant_depth;
    logic [N*3-1:0]  core_state;
    logic [1:0]      mod_state;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int hist [N];
    int ent [N];
    int exp_st [N];

    idle_ctl #(.NCORES(N), .RES_W(RW)) u_dut (
        .clk(clk), .rst(rst), .demote_en(demote_en), .res_thresh(res_thresh),
        .req_valid(req_valid), .req_depth(req_depth), .irq(irq),
        .grant_valid(grant_valid), .grant_depth(grant_depth),
        .core_state(core_state), .mod_state(mod_state)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int st(input int c);
        return int'(core_state[c*3 +: 3]);
    endfunction

    task automatic enter(input int c, input int d, input bit same_irq, input string tag);
        int e;
        @(negedge clk);
        req_valid[c] = 1'b1;
        req_depth[c*3 +: 3] = 3'(d);
        irq[c] = same_irq;
        if (same_irq) e = 0;
        else if (demote_en && d >= 3 && hist[c] < 2) e = 1;
        else e = d;
        @(negedge clk);
        req_valid = '0;
        irq = '0;
        check(grant_valid[c] == 1'b1, {tag, " grant strobe"}, int'(grant_valid[c]), 1);
        check(int'(grant_depth[c*3 +: 3]) == e, {tag, " granted depth"}, int'(grant_depth[c*3 +: 3]), e);
        check(st(c) == e, {tag, " state"}, st(c), e);
        exp_st[c] = e;
        ent[c] = cyc;
    endtask

    task automatic leave(input logic [N-1:0] mask);
        int r;
        irq = mask;
        for (int c = 0; c < N; c++) begin
            if (mask[c] && exp_st[c] != 0) begin
                r = cyc - ent[c];
                if (r > RMAX) r = RMAX;
                if (r >= int'(res_thresh)) hist[c] = (hist[c] == 3) ? 3 : hist[c] + 1;
                else hist[c] = (hist[c] == 0) ? 0 : hist[c] - 1;
                exp_st[c] = 0;
            end
        end
        @(negedge clk);
        irq = '0;
        for (int c = 0; c < N; c++)
            if (mask[c]) check(st(c) == 0, "R3 wake to running", st(c), 0);
    endtask

    task automatic sleep_cycle(input int c, input int d, input int k, input bit same_irq,
                               input string tag);
        enter(c, d, same_irq, tag);
        if (exp_st[c] != 0) begin
            repeat (k) @(negedge clk);
            leave(N'(1) << c);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        finish_run();
    end

    initial begin
        for (int c = 0; c < N; c++) begin hist[c] = 0; exp_st[c] = 0; ent[c] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        for (int c = 0; c < N; c++) begin
            check(st(c) == 0, "R1 state after reset", st(c), 0);
            check(grant_valid[c] == 1'b0, "R1 no grant after reset", int'(grant_valid[c]), 0);
        end
        check(mod_state == 2'd0, "R1 module state", int'(mod_state), 0);
        // R1: history starts at zero, so a deep request is demoted
        demote_en = 1'b1;
        sleep_cycle(0, 6, 1, 1'b0, "R1 history zero");
        demote_en = 1'b0;

        // R2: every depth on every core granted as asked
        for (int c = 0; c < N; c++)
            for (int d = 0; d < 7; d++)
                sleep_cycle(c, d, 2, 1'b0, "R2");

        // R4: request with interrupt in the same cycle
        for (int c = 0; c < N; c++)
            sleep_cycle(c, 5, 0, 1'b1, "R4");

        // R5: request to a sleeping core is ignored
        enter(0, 1, 1'b0, "R5 setup");
        @(negedge clk);
        req_valid[0] = 1'b1;
        req_depth[2:0] = 3'd6;
        @(negedge clk);
        req_valid = '0;
        check(grant_valid[0] == 1'b0, "R5 no grant while asleep", int'(grant_valid[0]), 0);
        check(st(0) == 1, "R5 state unchanged", st(0), 1);
        leave(4'b0001);

        // R6/R7: sweep depths and sleep lengths around the threshold
        demote_en = 1'b1;
        res_thresh = 8'd4;
        for (int c = 0; c < N; c++)
            for (int i = 0; i < 20; i++)
                sleep_cycle(c, 1 + ((i + c) % 6), 2 + ((i * 3 + c) % 5), 1'b0, "R6 R7 sweep");

        // R7: build history on core 2 with long sleeps, then deep grant
        for (int i = 0; i < 3; i++) sleep_cycle(2, 1, 6, 1'b0, "R7 long");
        sleep_cycle(2, 4, 6, 1'b0, "R7 deep allowed");
        // R8: short sleeps pull it back to demotion
        for (int i = 0; i < 3; i++) sleep_cycle(2, 1, 1, 1'b0, "R8 short");
        sleep_cycle(2, 6, 1, 1'b0, "R8 demoted again");
        check(hist[2] < 2, "R8 model history low", hist[2], 1);

        // R9: module state combinations
        demote_en = 1'b0;
        enter(0, 3, 1'b0, "R9 setup");
        check(mod_state == 2'd0, "R9 one core deep", int'(mod_state), 0);
        enter(1, 4, 1'b0, "R9 setup");
        enter(2, 5, 1'b0, "R9 setup");
        check(mod_state == 2'd0, "R9 one core running", int'(mod_state), 0);
        enter(3, 6, 1'b0, "R9 setup");
        check(mod_state == 2'd2, "R9 all deep", int'(mod_state), 2);
        leave(4'b0100);
        check(mod_state == 2'd0, "R9 one woken", int'(mod_state), 0);
        enter(2, 2, 1'b0, "R9 setup");
        check(mod_state == 2'd1, "R9 all idle one shallow", int'(mod_state), 1);
        leave(4'b1111);
        check(mod_state == 2'd0, "R9 all woken", int'(mod_state), 0);

        // R10: saturating residency with threshold at maximum
        demote_en = 1'b1;
        for (int i = 0; i < 3; i++) sleep_cycle(3, 1, 1, 1'b0, "R10 setup");
        res_thresh = 8'(RMAX);
        for (int i = 0; i < 3; i++) sleep_cycle(3, 2, 300, 1'b0, "R10 overlong");
        sleep_cycle(3, 6, 1, 1'b0, "R10 deep after saturated sleeps");
        check(hist[3] == 2, "R10 model history", hist[3], 2);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule